// File: doc/BRIEF.md
# Macroblock Motion Mask Generator

This block converts per-macroblock motion search results into a one-bit-per-block motion mask for each video frame. A frame begins with a start pulse that samples the two thresholds and the picture-size mode. Records then arrive in raster order, one per accepted cycle. Each record carries a block's sum of absolute differences (SAD) and a signed motion vector. The block keeps the final mask of the frame before, so that objects which slow down or stop stay marked for one more frame.

Three rules decide each mask bit. The first is a primary threshold on SAD with a moving vector. The second is a much lower threshold, applied only where the previous mask was set. The third is a hole-fill step, which sets a clear block when enough of its eight neighbours are set. Once every record has arrived, the block scans the grid and emits the final mask one bit per cycle in raster order. It writes each bit back as the previous mask for the next frame, then pulses a done flag. Labelling of connected objects and centroid computation belong to logic downstream.

Top module: `mmg_motion_mask`

## Requirements
- R1: While reset is active, mask_valid_o and done_o are 0. Reset clears the stored previous mask, so the first frame after reset gets no persistence.
- R2: A start pulse seen in idle samples mode_i. Mode 0 selects a grid of 9 rows by 11 columns, and mode 1 selects 18 rows by 22 columns. The frame then accepts exactly rows*cols records and emits exactly rows*cols mask bits.
- R3: Primary rule: a block is set when its SAD is greater than or equal to the high threshold and its vector is not (0,0). Otherwise the rule leaves the block clear.
- R4: Persistence rule: a block whose previous-frame bit is 1 is also set when its SAD is greater than or equal to the low threshold, whatever its vector.
- R5: Persistence lasts one frame. A block kept only by persistence is cleared in the following frame unless its SAD again meets one of the two rules.
- R6: Fill rule: a clear block becomes 1 when 4 or more of its 8 surrounding blocks are 1. Positions outside the grid count as 0. A set block is never cleared by this rule.
- R7: Neighbour counts use only the result of the first two rules. A block set by the fill rule does not add to any other block's count.
- R8: Output order and storage: during the scan, mask_valid_o stays high for rows*cols consecutive cycles and mask_bit_o gives the bits in raster order (row-major, column 0 first). Each final bit becomes the previous-frame bit for its position.
- R9: done_o is high for exactly one cycle. That cycle directly follows the last mask bit, and mask_valid_o is low in it.
- R10: Thresholds and mode are latched at the start pulse. Changes on thr_hi_i, thr_lo_i and mode_i later in the frame have no effect on that frame.
- R11: A start pulse during a frame is ignored. So is rec_valid_i outside the record phase. Idle cycles between records are allowed.
- R12: At each frame start, previous-mask bits at positions outside the new grid are cleared. A later switch to the larger grid therefore sees no stale persistence there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start pulse, accepted in idle |
| mode_i | input | 1 | Grid select: 0 = 9x11, 1 = 18x22 |
| thr_hi_i | input | SAD_W | Primary SAD threshold |
| thr_lo_i | input | SAD_W | Persistence SAD threshold |
| rec_valid_i | input | 1 | Record present this cycle |
| rec_sad_i | input | SAD_W | Block SAD |
| rec_mvx_i | input | MV_W | Horizontal vector component, signed |
| rec_mvy_i | input | MV_W | Vertical vector component, signed |
| mask_valid_o | output | 1 | Mask bit valid |
| mask_bit_o | output | 1 | Final mask bit, raster order |
| done_o | output | 1 | One-cycle pulse after the last mask bit |

## Verification
The bench aims at threshold equality, where an off-by-one compare drops blocks whose SAD equals a threshold. It also covers zero vectors above the high threshold, which a design ignoring the vector test would mark. Persistence is checked on the first frame after reset and across two consecutive frames: a design that keeps stale state, or that lets persistence chain, marks blocks that should be clear. Fill patterns with exactly three and exactly four neighbours, at corners, and in a chain where one fill would feed another catch count and snapshot errors. Mode changes between frames, and changes to the thresholds and mode in the middle of a frame, expose grids with the wrong size or stale grids, and late sampling.

// File: rtl/mmg_pkg.sv
package mmg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_SCAN = 2'd2
  } mmg_state_e;
endpackage

// File: rtl/mmg_ctrl.sv
module mmg_ctrl
  import mmg_pkg::*;
#(
  parameter int SMALL_ROWS = 9,
  parameter int SMALL_COLS = 11,
  parameter int LARGE_ROWS = 18,
  parameter int LARGE_COLS = 22,
  localparam int RCW = $clog2(LARGE_ROWS + 1),
  localparam int CCW = $clog2(LARGE_COLS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           mode_i,
  input  logic           rec_valid_i,
  output logic           frame_start_o,
  output logic           rec_fire_o,
  output logic           scan_fire_o,
  output logic           mode_q_o,
  output logic [RCW-1:0] row_o,
  output logic [CCW-1:0] col_o,
  output logic [RCW-1:0] rows_o,
  output logic [CCW-1:0] cols_o,
  output logic           done_o
);
  mmg_state_e     state_q;
  logic           mode_q, eff_mode, done_q, last_pos;
  logic [RCW-1:0] row_q;
  logic [CCW-1:0] col_q;

  // in idle the grid follows the pin so pruning at start uses the new size
  assign eff_mode = (state_q == ST_IDLE) ? mode_i : mode_q;
  assign rows_o   = eff_mode ? RCW'(LARGE_ROWS) : RCW'(SMALL_ROWS);
  assign cols_o   = eff_mode ? CCW'(LARGE_COLS) : CCW'(SMALL_COLS);
  assign last_pos = (row_q == rows_o - 1'b1) && (col_q == cols_o - 1'b1);

  assign frame_start_o = (state_q == ST_IDLE) && start_i;
  assign rec_fire_o    = (state_q == ST_RECV) && rec_valid_i;
  assign scan_fire_o   = (state_q == ST_SCAN);
  assign mode_q_o      = mode_q;
  assign row_o         = row_q;
  assign col_o         = col_q;
  assign done_o        = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (frame_start_o) begin
        state_q <= ST_RECV;
        mode_q  <= mode_i;
        row_q   <= '0;
        col_q   <= '0;
      end else if (rec_fire_o || scan_fire_o) begin
        if (last_pos) begin
          row_q   <= '0;
          col_q   <= '0;
          state_q <= scan_fire_o ? ST_IDLE : ST_SCAN;
          done_q  <= scan_fire_o;
        end else if (col_q == cols_o - 1'b1) begin
          col_q <= '0;
          row_q <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mmg_decide.sv
module mmg_decide #(
  parameter int SAD_W = 16,
  parameter int MV_W  = 8
) (
  input  logic [SAD_W-1:0]       sad_i,
  input  logic signed [MV_W-1:0] mvx_i,
  input  logic signed [MV_W-1:0] mvy_i,
  input  logic [SAD_W-1:0]       thr_hi_i,
  input  logic [SAD_W-1:0]       thr_lo_i,
  input  logic                   prev_i,
  output logic                   bit_o
);
  logic moving, primary, persist;

  assign moving  = (mvx_i != '0) || (mvy_i != '0);
  assign primary = (sad_i >= thr_hi_i) && moving;
  // persistence only adds bits, so it merges with the primary rule per record
  assign persist = prev_i && (sad_i >= thr_lo_i);
  assign bit_o   = primary || persist;
endmodule

// File: rtl/mmg_fill.sv
module mmg_fill #(
  parameter int LARGE_ROWS = 18,
  parameter int LARGE_COLS = 22,
  parameter int FILL_MIN   = 4,
  localparam int N   = LARGE_ROWS * LARGE_COLS,
  localparam int IW  = $clog2(N),
  localparam int RCW = $clog2(LARGE_ROWS + 1),
  localparam int CCW = $clog2(LARGE_COLS + 1)
) (
  input  logic [N-1:0]   cur_i,
  input  logic [IW-1:0]  idx_i,
  input  logic [RCW-1:0] row_i,
  input  logic [CCW-1:0] col_i,
  input  logic [RCW-1:0] rows_i,
  input  logic [CCW-1:0] cols_i,
  output logic           self_o,
  output logic           fill_o
);
  logic [3:0] cnt;

  always_comb begin
    int nr, nc;
    cnt = '0;
    for (int dr = -1; dr <= 1; dr++) begin
      for (int dc = -1; dc <= 1; dc++) begin
        nr = int'(row_i) + dr;
        nc = int'(col_i) + dc;
        if (!(dr == 0 && dc == 0) && nr >= 0 && nc >= 0 &&
            nr < int'(rows_i) && nc < int'(cols_i)) begin
          cnt = cnt + 4'(cur_i[IW'(nr * LARGE_COLS + nc)]);
        end
      end
    end
  end

  assign self_o = cur_i[idx_i];
  assign fill_o = self_o || (cnt >= 4'(FILL_MIN));
endmodule

// File: rtl/mmg_motion_mask.sv
module mmg_motion_mask #(
  parameter int SAD_W      = 16,
  parameter int MV_W       = 8,
  parameter int SMALL_ROWS = 9,
  parameter int SMALL_COLS = 11,
  parameter int LARGE_ROWS = 18,
  parameter int LARGE_COLS = 22,
  parameter int FILL_MIN   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   mode_i,
  input  logic [SAD_W-1:0]       thr_hi_i,
  input  logic [SAD_W-1:0]       thr_lo_i,
  input  logic                   rec_valid_i,
  input  logic [SAD_W-1:0]       rec_sad_i,
  input  logic signed [MV_W-1:0] rec_mvx_i,
  input  logic signed [MV_W-1:0] rec_mvy_i,
  output logic                   mask_valid_o,
  output logic                   mask_bit_o,
  output logic                   done_o
);
  localparam int N   = LARGE_ROWS * LARGE_COLS;
  localparam int IW  = $clog2(N);
  localparam int RCW = $clog2(LARGE_ROWS + 1);
  localparam int CCW = $clog2(LARGE_COLS + 1);

  logic             frame_start, rec_fire, scan_fire, mode_q;
  logic [RCW-1:0]   row, rows;
  logic [CCW-1:0]   col, cols;
  logic [IW-1:0]    pos_idx;
  logic [N-1:0]     prev_q, cur_q, grid_mask;
  logic [SAD_W-1:0] thr_hi_q, thr_lo_q;
  logic             decide_bit, self_bit, fill_bit;

  mmg_ctrl #(
    .SMALL_ROWS(SMALL_ROWS), .SMALL_COLS(SMALL_COLS),
    .LARGE_ROWS(LARGE_ROWS), .LARGE_COLS(LARGE_COLS)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .rec_valid_i  (rec_valid_i),
    .frame_start_o(frame_start),
    .rec_fire_o   (rec_fire),
    .scan_fire_o  (scan_fire),
    .mode_q_o     (mode_q),
    .row_o        (row),
    .col_o        (col),
    .rows_o       (rows),
    .cols_o       (cols),
    .done_o       (done_o)
  );

  assign pos_idx = IW'(row) * IW'(LARGE_COLS) + IW'(col);

  for (genvar g = 0; g < N; g++) begin : g_grid
    localparam int GR = g / LARGE_COLS;
    localparam int GC = g % LARGE_COLS;
    assign grid_mask[g] = (RCW'(GR) < rows) && (CCW'(GC) < cols);
  end

  mmg_decide #(.SAD_W(SAD_W), .MV_W(MV_W)) u_decide (
    .sad_i   (rec_sad_i),
    .mvx_i   (rec_mvx_i),
    .mvy_i   (rec_mvy_i),
    .thr_hi_i(thr_hi_q),
    .thr_lo_i(thr_lo_q),
    .prev_i  (prev_q[pos_idx]),
    .bit_o   (decide_bit)
  );

  mmg_fill #(
    .LARGE_ROWS(LARGE_ROWS), .LARGE_COLS(LARGE_COLS), .FILL_MIN(FILL_MIN)
  ) u_fill (
    .cur_i (cur_q),
    .idx_i (pos_idx),
    .row_i (row),
    .col_i (col),
    .rows_i(rows),
    .cols_i(cols),
    .self_o(self_bit),
    .fill_o(fill_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      cur_q    <= '0;
      thr_hi_q <= '0;
      thr_lo_q <= '0;
    end else if (frame_start) begin
      cur_q    <= '0;
      prev_q   <= prev_q & grid_mask;
      thr_hi_q <= thr_hi_i;
      thr_lo_q <= thr_lo_i;
    end else if (rec_fire) begin
      cur_q[pos_idx] <= decide_bit;
    end else if (scan_fire) begin
      // cur_q is frozen during the scan, which gives the fill its snapshot
      prev_q[pos_idx] <= fill_bit;
    end
  end

  assign mask_valid_o = scan_fire;
  assign mask_bit_o   = fill_bit;
endmodule

// File: rtl/mmg_chk.sv
module mmg_chk #(
  parameter int SAD_W      = 16,
  parameter int SMALL_ROWS = 9,
  parameter int SMALL_COLS = 11,
  parameter int LARGE_ROWS = 18,
  parameter int LARGE_COLS = 22
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mask_valid_o,
  input logic             mask_bit_o,
  input logic             done_o,
  input logic             self_bit_i,
  input logic             mode_q_i,
  input logic [SAD_W-1:0] thr_hi_q_i,
  input logic [SAD_W-1:0] thr_lo_q_i
);
  localparam int N  = LARGE_ROWS * LARGE_COLS;
  localparam int BW = $clog2(N + 1);

  logic [BW-1:0] bit_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           bit_cnt <= '0;
    else if (done_o)       bit_cnt <= '0;
    else if (mask_valid_o) bit_cnt <= bit_cnt + 1'b1;
  end

  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!mask_valid_o && !done_o);
    end
  end

  // R2
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bit_cnt == (mode_q_i ? BW'(N) : BW'(SMALL_ROWS * SMALL_COLS))));

  // R6
  fill_keeps_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_valid_o && self_bit_i) |-> mask_bit_o);

  // R8
  scan_contiguous_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_valid_o |=> (mask_valid_o || done_o));

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_after_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(mask_valid_o) && !mask_valid_o));

  // R10
  cfg_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_valid_o |-> ($stable(thr_hi_q_i) && $stable(thr_lo_q_i) && $stable(mode_q_i)));
endmodule

bind mmg_motion_mask mmg_chk #(
  .SAD_W(SAD_W), .SMALL_ROWS(SMALL_ROWS), .SMALL_COLS(SMALL_COLS),
  .LARGE_ROWS(LARGE_ROWS), .LARGE_COLS(LARGE_COLS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mask_valid_o(mask_valid_o),
  .mask_bit_o  (mask_bit_o),
  .done_o      (done_o),
  .self_bit_i  (self_bit),
  .mode_q_i    (mode_q),
  .thr_hi_q_i  (thr_hi_q),
  .thr_lo_q_i  (thr_lo_q)
);

// File: tb/mmg_motion_mask_tb.sv
module mmg_motion_mask_tb;
  localparam int LR = 18;
  localparam int LC = 22;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic              mode_i = 1'b0;
  logic [15:0]       thr_hi_i = '0;
  logic [15:0]       thr_lo_i = '0;
  logic              rec_valid_i = 1'b0;
  logic [15:0]       rec_sad_i = '0;
  logic signed [7:0] rec_mvx_i = '0;
  logic signed [7:0] rec_mvy_i = '0;
  logic              mask_valid_o, mask_bit_o, done_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  int sad_a [LR][LC];
  int mvx_a [LR][LC];
  int mvy_a [LR][LC];
  bit prev_m[LR][LC];
  bit p12_m [LR][LC];
  bit exp_m [LR][LC];

  always #2.5 clk_i = ~clk_i;

  mmg_motion_mask u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .thr_hi_i(thr_hi_i), .thr_lo_i(thr_lo_i), .rec_valid_i(rec_valid_i),
    .rec_sad_i(rec_sad_i), .rec_mvx_i(rec_mvx_i), .rec_mvy_i(rec_mvy_i),
    .mask_valid_o(mask_valid_o), .mask_bit_o(mask_bit_o), .done_o(done_o)
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, got cycle %0d expected finish earlier", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic fill_all(input int sad, input int mx, input int my);
    for (int r = 0; r < LR; r++)
      for (int c = 0; c < LC; c++) begin
        sad_a[r][c] = sad; mvx_a[r][c] = mx; mvy_a[r][c] = my;
      end
  endtask

  task automatic set_blk(input int r, input int c, input int sad, input int mx, input int my);
    sad_a[r][c] = sad; mvx_a[r][c] = mx; mvy_a[r][c] = my;
  endtask

  task automatic model_frame(input bit md, input int hi, input int lo);
    int rows = md ? 18 : 9;
    int cols = md ? 22 : 11;
    for (int r = 0; r < LR; r++)
      for (int c = 0; c < LC; c++) begin
        if (r >= rows || c >= cols) prev_m[r][c] = 1'b0;
        p12_m[r][c] = 1'b0;
      end
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++)
        p12_m[r][c] = (sad_a[r][c] >= hi && (mvx_a[r][c] != 0 || mvy_a[r][c] != 0)) ||
                      (prev_m[r][c] && sad_a[r][c] >= lo);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) begin
        int n = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++) begin
            int nr = r + dr;
            int nc = c + dc;
            if (!(dr == 0 && dc == 0) && nr >= 0 && nc >= 0 && nr < rows && nc < cols)
              n += int'(p12_m[nr][nc]);
          end
        exp_m[r][c] = p12_m[r][c] || (n >= 4);
      end
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) prev_m[r][c] = exp_m[r][c];
  endtask

  task automatic run_frame(input bit md, input int hi, input int lo, input string tag,
                           input bit gaps);
    int rows = md ? 18 : 9;
    int cols = md ? 22 : 11;
    int total = rows * cols;
    int k = 0;
    model_frame(md, hi, lo);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = md; thr_hi_i = 16'(hi); thr_lo_i = 16'(lo);
    @(negedge clk_i);
    // R10: alter configuration after the start pulse
    start_i = 1'b0; mode_i = ~md; thr_hi_i = '0; thr_lo_i = '0;
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) begin
        if (gaps && ($urandom % 4 == 0)) begin
          rec_valid_i = 1'b0;
          rec_sad_i = 16'hffff;
          @(negedge clk_i);
        end
        rec_valid_i = 1'b1;
        rec_sad_i = 16'(sad_a[r][c]);
        rec_mvx_i = 8'(mvx_a[r][c]);
        rec_mvy_i = 8'(mvy_a[r][c]);
        @(negedge clk_i);
      end
    rec_valid_i = 1'b0;
    while (k < total) begin
      if (!mask_valid_o) begin
        chk({tag, " R8 valid"}, 0, 1);
        break;
      end
      checks++;
      if (mask_bit_o != exp_m[k / cols][k % cols]) begin
        fails++;
        $display("FAIL %s R8 pos r%0d c%0d: got %0d expected %0d", tag, k / cols, k % cols,
                 mask_bit_o, exp_m[k / cols][k % cols]);
      end
      k++;
      // R11: stray start and records during the scan
      start_i = (k == 3);
      rec_valid_i = (k == 3) || (k == 4);
      rec_sad_i = 16'hffff; rec_mvx_i = 8'sd1;
      @(negedge clk_i);
    end
    start_i = 1'b0; rec_valid_i = 1'b0;
    chk({tag, " R9 done"}, int'(done_o), 1);
    chk({tag, " R9 valid low"}, int'(mask_valid_o), 0);
    @(negedge clk_i);
    chk({tag, " R9 done pulse"}, int'(done_o), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < LR; r++)
      for (int c = 0; c < LC; c++) prev_m[r][c] = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1 outputs quiet in reset
    chk("R1 valid in reset", int'(mask_valid_o), 0);
    chk("R1 done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid after reset", int'(mask_valid_o), 0);

    // R1 first frame: SAD equals low threshold, no persistence possible
    fill_all(50, 1, 0);
    run_frame(1'b1, 200, 50, "R1 first", 1'b0);

    // R3: equality, zero vector, one-component vectors, below threshold
    fill_all(0, 0, 0);
    set_blk(0, 0, 200, 0, 1);
    set_blk(2, 3, 200, -1, 0);
    set_blk(4, 4, 900, 0, 0);
    set_blk(6, 7, 199, 3, 3);
    set_blk(8, 10, 300, 2, -2);
    run_frame(1'b0, 200, 50, "R3 rule", 1'b1);

    // R4: previous bits with SAD at low threshold and zero vector
    fill_all(50, 0, 0);
    set_blk(1, 1, 49, 0, 0);
    run_frame(1'b0, 200, 50, "R4 persist", 1'b0);

    // R5: persisted bits at SAD at low threshold survive once, then drop
    fill_all(49, 0, 0);
    run_frame(1'b0, 200, 50, "R5 expire", 1'b0);

    // R6: full ring fills, three neighbours and corner do not
    fill_all(0, 0, 0);
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        if (!(dr == 0 && dc == 0)) set_blk(4 + dr, 5 + dc, 500, 1, 1);
    set_blk(0, 1, 500, 1, 0); set_blk(1, 0, 500, 1, 0); set_blk(1, 1, 500, 1, 0);
    set_blk(7, 8, 500, 0, 1); set_blk(8, 8, 500, 0, 1); set_blk(8, 9, 500, 0, 1);
    set_blk(3, 0, 500, 1, 0); set_blk(4, 0, 500, 1, 0); set_blk(5, 0, 500, 1, 0);
    set_blk(4, 1, 0, 0, 0);
    run_frame(1'b0, 200, 50, "R6 fill", 1'b1);

    // R7: a filled block must not count toward its neighbour
    fill_all(0, 0, 0);
    set_blk(1, 1, 500, 1, 0); set_blk(1, 2, 500, 1, 0); set_blk(1, 3, 500, 1, 0);
    set_blk(2, 1, 500, 1, 0); set_blk(1, 4, 500, 1, 0);
    run_frame(1'b1, 200, 50, "R7 snap", 1'b0);
    chk("R7 model filled (2,2)", int'(exp_m[2][2]), 1);
    chk("R7 model kept (2,3)", int'(exp_m[2][3]), 0);

    // R12: large frame sets outer blocks, small frame, then large again with low SAD
    fill_all(600, 2, 2);
    run_frame(1'b1, 200, 50, "R12 load", 1'b0);
    fill_all(0, 0, 0);
    run_frame(1'b0, 200, 50, "R12 small", 1'b0);
    fill_all(60, 0, 0);
    run_frame(1'b1, 200, 50, "R12 large", 1'b1);

    // R2 mixed random frames
    for (int f = 0; f < 16; f++) begin
      bit md = 1'($urandom % 2);
      int hi = 150 + int'($urandom % 200);
      int lo = hi / 4;
      int span = hi + 40 + int'($urandom % 300);
      for (int r = 0; r < LR; r++)
        for (int c = 0; c < LC; c++) begin
          int mx = ($urandom % 3 == 0) ? 0 : int'($urandom % 9) - 4;
          int my = ($urandom % 3 == 0) ? 0 : int'($urandom % 9) - 4;
          set_blk(r, c, int'($urandom % span), mx, my);
        end
      run_frame(md, hi, lo, "R2 random", 1'($urandom % 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule